// File: doc/BRIEF.md
# Dual-Host Edge-Triggered Interrupt Bank

This block collects up to 24 asynchronous interrupt sources and reports them to two independent host processors. Each source is synchronised, then passed through an edge detector whose trigger (rising, falling, both or none) comes from one edge-select register shared by both hosts. Every detected event sets a bit in two separate status copies, one per host. Each host has its own mask and its own active-low interrupt output, so it can mask and acknowledge its own copy without disturbing the other host.

Software reaches every register over a byte-wide bus with address, read strobe, write strobe and write data. Read data is registered and appears one cycle after the read strobe. A control bit selects how status is acknowledged. In clear-on-read mode, reading a status byte clears it. In write-one-to-clear mode, software writes ones to the bits it wants cleared. A second event that arrives while a bit is still pending is held and sets the bit again after the acknowledge. A test register lets software raise status bits in both copies.

Register map (5-bit address, bytes per block: S = ceil(N/8), E = ceil(2N/8)): host-0 status at 0x00+b, host-0 mask at 0x04+b, host-1 status at 0x08+b, host-1 mask at 0x0C+b, edge-select at 0x10+b, control at 0x16 (bit 0 = clear-on-read), test-set at 0x18+b. Source i occupies bit i%8 of status/mask/test byte i/8.

Top module: `dual_host_irq_bank`

## Requirements
- R1: After reset both `irq_n` bits are 1. Every implemented mask bit reads 1 and pad bits read 0, so with 18 sources mask byte 2 reads 0x03. Edge-select and control read 0x00, and unmapped addresses read 0x00.
- R2: Source i uses edge-select byte i/4, bits 2*(i%4)+1 (rising enable) and 2*(i%4) (falling enable). With only the rising bit set, a 0-to-1 input transition sets the source's status bit and a 1-to-0 transition does not.
- R3: With only the falling bit set, only a 1-to-0 transition sets status. With both bits set, both transitions set it.
- R4: A source whose two edge bits are 0 never sets status, even when unmasked.
- R5: A detected event sets the source's bit in both hosts' status copies.
- R6: `irq_n[h]` is 0 exactly when host h's status AND NOT mask is non-zero. It is registered, so it changes one clock after the status changes.
- R7: With control bit 0 clear, writing 1 to a status bit clears it, writing 0 leaves it alone, and reading does not clear it.
- R8: With control bit 0 set, reading a status byte returns its value and then clears it. Writes to status bytes have no effect.
- R9: Acknowledging one host's status never changes the other host's status.
- R10: An event arriving while its status bit is already set is buffered. After the first acknowledge the bit reads 1 again, and after a second acknowledge it reads 0.
- R11: Writing 1 to a test-set bit sets that source's status bit in both host copies, as a real event would.
- R12: When an event and an acknowledge hit the same set bit in the same cycle, the bit stays set. One further acknowledge then clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Asynchronous interrupt sources |
| bus_addr | input | 5 | Register byte address |
| bus_rd | input | 1 | Read strobe; data returned next cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_n | output | 2 | Active-low interrupt, bit h serves host h |

## Verification
The bench times a rising input so that its event lands in the same cycle as a write-one-to-clear. A design that lets the clear win would silently lose that interrupt and read back 0. It also sends two events before any acknowledge: a design without the pending buffer drops the second event, and one with the wrong reload logic never clears. In clear-on-read mode the bench checks that a read empties only the host it addressed, since a design sharing a single status set would empty both. It also checks the exact cycle in which the interrupt output falls, which catches an unregistered or doubly registered output.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int ADDR_W = 5;
  typedef logic [ADDR_W-1:0] reg_addr_t;

  localparam reg_addr_t ADR_ST0  = 5'h00;
  localparam reg_addr_t ADR_MK0  = 5'h04;
  localparam reg_addr_t ADR_ST1  = 5'h08;
  localparam reg_addr_t ADR_MK1  = 5'h0C;
  localparam reg_addr_t ADR_EDGE = 5'h10;
  localparam reg_addr_t ADR_CTRL = 5'h16;
  localparam reg_addr_t ADR_TSET = 5'h18;

  function automatic int stat_bytes(input int n);
    return (n + 7) / 8;
  endfunction

  function automatic int edge_bytes(input int n);
    return (2 * n + 7) / 8;
  endfunction
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int N = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  output logic [N-1:0] evt
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= src_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_det
      assign evt[i] = (sync_q[i] & ~prev_q[i] & rise_en[i]) |
                      (~sync_q[i] & prev_q[i] & fall_en[i]);
    end
  endgenerate
endmodule

// File: rtl/irq_host_bank.sv
module irq_host_bank #(
  parameter int N  = 18,
  parameter int SB = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  evt,
  input  logic [N-1:0]  clr,
  input  logic [SB-1:0] mask_we,
  input  logic [7:0]    wdata,
  output logic [N-1:0]  status,
  output logic [N-1:0]  mask,
  output logic          irq_n
);
  logic [N-1:0] st_q, pend_q, mask_q;
  logic [N-1:0] clr_eff, st_next, pend_next, mask_next;

  always_comb begin
    clr_eff   = clr & st_q;
    st_next   = (st_q & ~clr_eff) | evt | (clr_eff & pend_q);
    pend_next = (clr_eff & pend_q & evt) | (~clr_eff & (pend_q | (evt & st_q)));
    for (int i = 0; i < N; i++)
      mask_next[i] = mask_we[i/8] ? wdata[i%8] : mask_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      pend_q <= '0;
      mask_q <= '1;
      irq_n  <= 1'b1;
    end else begin
      st_q   <= st_next;
      pend_q <= pend_next;
      mask_q <= mask_next;
      irq_n  <= ~|(st_q & ~mask_q);
    end
  end

  assign status = st_q;
  assign mask   = mask_q;
endmodule

// File: rtl/dual_host_irq_bank.sv
module dual_host_irq_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [4:0]         bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic [1:0]         irq_n
);
  localparam int SB = stat_bytes(NUM_SRC);
  localparam int EB = edge_bytes(NUM_SRC);
  localparam int SW = SB * 8;
  localparam int EW = EB * 8;
  localparam int CW = 2 * NUM_SRC;

  function automatic logic hit(input reg_addr_t base, input int idx, input reg_addr_t a);
    return a == (base + reg_addr_t'(idx));
  endfunction

  // shared edge-select and control
  logic [CW-1:0]      edge_q;
  logic               cor_q;
  logic [NUM_SRC-1:0] rise_en, fall_en, evt_src, tst_set, evt_all;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_q <= '0;
      cor_q  <= 1'b0;
    end else if (bus_wr) begin
      for (int k = 0; k < CW; k++)
        if (hit(ADR_EDGE, k / 8, bus_addr)) edge_q[k] <= bus_wdata[k%8];
      if (bus_addr == ADR_CTRL) cor_q <= bus_wdata[0];
    end
  end

  genvar i, h;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_cfg
      assign rise_en[i] = edge_q[2*i+1];
      assign fall_en[i] = edge_q[2*i];
    end
  endgenerate

  irq_edge_detect #(.N(NUM_SRC)) u_det (
    .clk(clk), .rst(rst), .src_in(src_in),
    .rise_en(rise_en), .fall_en(fall_en), .evt(evt_src)
  );

  always_comb begin
    for (int k = 0; k < NUM_SRC; k++)
      tst_set[k] = bus_wr && hit(ADR_TSET, k / 8, bus_addr) && bus_wdata[k%8];
  end

  assign evt_all = evt_src | tst_set;

  // per-host status and mask copies
  logic [NUM_SRC-1:0] st_q [2];
  logic [NUM_SRC-1:0] mk_q [2];

  generate
    for (h = 0; h < 2; h++) begin : g_host
      localparam reg_addr_t ST_BASE = (h == 0) ? ADR_ST0 : ADR_ST1;
      localparam reg_addr_t MK_BASE = (h == 0) ? ADR_MK0 : ADR_MK1;
      logic [NUM_SRC-1:0] clr;
      logic [SB-1:0]      mask_we;

      always_comb begin
        for (int k = 0; k < NUM_SRC; k++) begin
          if (hit(ST_BASE, k / 8, bus_addr))
            clr[k] = cor_q ? bus_rd : (bus_wr & bus_wdata[k%8]);
          else
            clr[k] = 1'b0;
        end
        for (int b = 0; b < SB; b++)
          mask_we[b] = bus_wr && hit(MK_BASE, b, bus_addr);
      end

      irq_host_bank #(.N(NUM_SRC), .SB(SB)) u_bank (
        .clk(clk), .rst(rst), .evt(evt_all), .clr(clr),
        .mask_we(mask_we), .wdata(bus_wdata),
        .status(st_q[h]), .mask(mk_q[h]), .irq_n(irq_n[h])
      );
    end
  endgenerate

  // registered read path
  logic [SW-1:0] st_pad0, st_pad1, mk_pad0, mk_pad1;
  logic [EW-1:0] edge_pad;
  logic [7:0]    rd_mux;

  assign st_pad0  = SW'(st_q[0]);
  assign st_pad1  = SW'(st_q[1]);
  assign mk_pad0  = SW'(mk_q[0]);
  assign mk_pad1  = SW'(mk_q[1]);
  assign edge_pad = EW'(edge_q);

  always_comb begin
    rd_mux = 8'h00;
    for (int b = 0; b < SB; b++) begin
      if (hit(ADR_ST0, b, bus_addr)) rd_mux = st_pad0[b*8 +: 8];
      if (hit(ADR_MK0, b, bus_addr)) rd_mux = mk_pad0[b*8 +: 8];
      if (hit(ADR_ST1, b, bus_addr)) rd_mux = st_pad1[b*8 +: 8];
      if (hit(ADR_MK1, b, bus_addr)) rd_mux = mk_pad1[b*8 +: 8];
    end
    for (int b = 0; b < EB; b++)
      if (hit(ADR_EDGE, b, bus_addr)) rd_mux = edge_pad[b*8 +: 8];
    if (bus_addr == ADR_CTRL) rd_mux = {7'b0, cor_q};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_bank_checker.sv
module irq_bank_checker #(
  parameter int N  = 18,
  parameter int CW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    irq_n,
  input logic [N-1:0]  st0,
  input logic [N-1:0]  st1,
  input logic [N-1:0]  mk0,
  input logic [N-1:0]  mk1,
  input logic [N-1:0]  evt,
  input logic [CW-1:0] edge_cfg,
  input logic [4:0]    bus_addr,
  input logic          bus_wr
);
  logic tset_hit;
  assign tset_hit = bus_wr && (bus_addr >= 5'h18);

  p_irq_follow_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n[0] == ~|$past(st0 & ~mk0)) && (irq_n[1] == ~|$past(st1 & ~mk1)));

  p_mask_init_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mk0 == '1) && (mk1 == '1) && (irq_n == 2'b11));

  p_edge_init_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (edge_cfg == '0));

  p_no_trigger_r4: assert property (@(posedge clk) disable iff (rst)
    ((edge_cfg == '0) && !tset_hit) |=> ((st0 & ~$past(st0)) == '0) && ((st1 & ~$past(st1)) == '0));

  p_hold_on_clear_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(st0 & evt) & ~st0) == '0) && (($past(st1 & evt) & ~st1) == '0));

  p_set_needs_event_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st0 & ~$past(st0) & ~$past(evt)) == '0) && ((st1 & ~$past(st1) & ~$past(evt)) == '0));
endmodule

bind dual_host_irq_bank irq_bank_checker #(.N(NUM_SRC), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .irq_n(irq_n),
  .st0(st_q[0]), .st1(st_q[1]), .mk0(mk_q[0]), .mk1(mk_q[1]),
  .evt(evt_all), .edge_cfg(edge_q), .bus_addr(bus_addr), .bus_wr(bus_wr)
);

// File: tb/dual_host_irq_bank_test.sv
module dual_host_irq_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] src_in = '0;
  logic [4:0]   bus_addr = '0;
  logic         bus_rd = 1'b0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic [1:0]   irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_host_irq_bank #(.NUM_SRC(N)) uut (
    .clk(clk), .rst(rst), .src_in(src_in), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_rd(input string tag, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_src(input int idx, input logic v);
    src_in[idx] = v;
    wait_cyc(5);
  endtask

  task automatic t_reset();
    chk("R1 irq_n", {6'b0, irq_n}, 8'h03);
    expect_rd("R1 mask0 byte0", 5'h04, 8'hFF);
    expect_rd("R1 mask1 byte2", 5'h0E, 8'h03);
    expect_rd("R1 edge byte0", 5'h10, 8'h00);
    expect_rd("R1 control", 5'h16, 8'h00);
    expect_rd("R1 unmapped", 5'h1F, 8'h00);
  endtask

  task automatic t_rising();
    wr(5'h11, 8'h08);                 // source 5 rising
    set_src(5, 1'b1);
    expect_rd("R2 rise host0", 5'h00, 8'h20);
    expect_rd("R5 rise host1", 5'h08, 8'h20);
    set_src(5, 1'b0);
    expect_rd("R7 read keeps status", 5'h00, 8'h20);
    wr(5'h00, 8'h20);
    expect_rd("R2 fall ignored, cleared", 5'h00, 8'h00);
    expect_rd("R9 host1 untouched", 5'h08, 8'h20);
    wr(5'h08, 8'h20);
  endtask

  task automatic t_falling();
    wr(5'h12, 8'h04);                 // source 9 falling
    set_src(9, 1'b1);
    expect_rd("R3 rise ignored", 5'h01, 8'h00);
    set_src(9, 1'b0);
    expect_rd("R3 fall detected", 5'h01, 8'h02);
    wr(5'h01, 8'h02); wr(5'h09, 8'h02);
    wr(5'h14, 8'h0C);                 // source 17 both edges
    set_src(17, 1'b1);
    expect_rd("R3 both rise", 5'h02, 8'h02);
    wr(5'h02, 8'h02);
    set_src(17, 1'b0);
    expect_rd("R3 both fall", 5'h02, 8'h02);
    wr(5'h02, 8'h02); wr(5'h09, 8'h02); wr(5'h0A, 8'h02);
    wr(5'h12, 8'h00); wr(5'h14, 8'h00);
  endtask

  task automatic t_notrig();
    wr(5'h04, 8'h00);                 // unmask host0 byte0
    set_src(0, 1'b1);
    set_src(0, 1'b0);
    expect_rd("R4 no trigger status", 5'h00, 8'h00);
    chk("R4 no trigger irq", {6'b0, irq_n}, 8'h03);
  endtask

  task automatic t_mask_and_test();
    wr(5'h18, 8'h20);                 // test set source 5
    chk("R6 irq not yet", {7'b0, irq_n[0]}, 8'h01);
    @(negedge clk);
    chk("R6 host0 irq asserted, host1 masked", {6'b0, irq_n}, 8'h02);
    expect_rd("R11 test set host1", 5'h08, 8'h20);
    wr(5'h00, 8'h00);
    wait_cyc(2);
    chk("R7 zero write no effect", {6'b0, irq_n}, 8'h02);
    wr(5'h00, 8'h20);
    wait_cyc(2);
    chk("R6 irq released", {6'b0, irq_n}, 8'h03);
    wr(5'h0C, 8'h00);
    wait_cyc(2);
    chk("R6 host1 unmasked", {6'b0, irq_n}, 8'h01);
    wr(5'h08, 8'h20);
    wr(5'h0C, 8'hFF);
    wait_cyc(2);
    chk("R6 host1 idle", {6'b0, irq_n}, 8'h03);
  endtask

  task automatic t_cor();
    wr(5'h16, 8'h01);
    expect_rd("R8 control readback", 5'h16, 8'h01);
    wr(5'h18, 8'h21);
    wr(5'h00, 8'hFF);
    expect_rd("R8 write ignored, read", 5'h00, 8'h21);
    expect_rd("R8 read cleared", 5'h00, 8'h00);
    expect_rd("R9 host1 kept", 5'h08, 8'h21);
    expect_rd("R9 host1 cleared", 5'h08, 8'h00);
    wr(5'h16, 8'h00);
  endtask

  task automatic t_buffer();
    set_src(5, 1'b1); set_src(5, 1'b0);
    set_src(5, 1'b1); set_src(5, 1'b0);
    expect_rd("R10 pending", 5'h00, 8'h20);
    wr(5'h00, 8'h20);
    expect_rd("R10 reloaded", 5'h00, 8'h20);
    wr(5'h00, 8'h20);
    expect_rd("R10 drained", 5'h00, 8'h00);
    wr(5'h08, 8'h20); wr(5'h08, 8'h20);
    expect_rd("R10 host1 drained", 5'h08, 8'h00);
  endtask

  task automatic t_same_cycle();
    set_src(5, 1'b1); set_src(5, 1'b0);
    wr(5'h08, 8'h20);
    src_in[5] = 1'b1;                 // event reaches status on the 3rd edge
    @(negedge clk);
    @(negedge clk);
    wr(5'h00, 8'h20);                 // clear on that same edge
    expect_rd("R12 kept set", 5'h00, 8'h20);
    wr(5'h00, 8'h20);
    expect_rd("R12 one more clear empties", 5'h00, 8'h00);
    src_in[5] = 1'b0;
    wait_cyc(5);
    wr(5'h08, 8'h20);
  endtask

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rising();
    t_falling();
    t_notrig();
    t_mask_and_test();
    t_cor();
    t_buffer();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule